// File: doc/BRIEF.md
# Real-Time Clock Event and Status Flag Unit

This block sits beside the counters of a real-time clock and turns their activity into a read-only status word of sticky flags. On every one-second tick it compares the current BCD time and calendar fields with the copy it captured at the previous tick. From that comparison it raises a seconds flag, a time-boundary flag and a calendar-boundary flag. Software picks the boundary through two select inputs. An alarm-match pulse from an external comparator sets an alarm flag.

The unit also grants update access to the counters. Software raises an update request, and the grant bit appears at the next second tick. The grant drops as soon as the request is withdrawn. Every cycle, a validity checker inspects the counter contents for non-BCD digits and out-of-range values. It raises an error flag that clears only on a status read, and only once the contents are valid again. The event flags and the grant are cleared through a write-one-to-clear port.

Top module: `rtc_evt_status`

## Requirements
- R1: The status word carries the update grant at bit 0, the alarm flag at bit 1, the seconds flag at bit 2, the time-boundary flag at bit 3, the calendar-boundary flag at bit 4 and the error flag at bit 5. Every higher bit reads 0. After reset the whole word is 0.
- R2: A cycle with `sec_tick` high sets the seconds flag, which is visible in the following cycle. The flag then stays high until it is cleared.
- R3: On a tick, the time-boundary flag is set according to `tev_sel`. Select 0 sets it when the minutes field differs from the previous tick. Select 1 sets it when the hours field differs. Select 2 (midnight) sets it when the hours field becomes 0x00. Select 3 (noon) sets it when the hours field becomes 0x12 while minutes and seconds are 0x00. The first tick after reset never sets it.
- R4: On a tick, the calendar-boundary flag is set according to `cev_sel`. Select 0 sets it when the day of week becomes 1 from another value. Select 1 sets it when the month field differs from the previous tick. Select 2 sets it when the year field differs. Select 3 never sets it. The first tick after reset never sets it.
- R5: An `alarm_hit` cycle sets the alarm flag, which is visible in the following cycle. The flag stays high until it is cleared.
- R6: While `upd_req` is high, a tick sets the update grant. While `upd_req` is low, the grant reads 0 from the following cycle on.
- R7: The error flag is set in any cycle where the fields are invalid. Fields are invalid when any BCD nibble exceeds 9, seconds or minutes exceed 0x59, hours exceed 0x23, month is outside 0x01..0x12, date is outside 0x01..0x31, or day of week is 0. A `rd_strobe` cycle clears the flag only if the fields are valid in that cycle.
- R8: A `clr_wr` cycle clears each of bits 0 to 4 whose `clr_data` bit is 1. Bit 5 and higher `clr_data` bits have no effect. When a set condition and a clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second from the counters |
| sec_bcd | input | 8 | Seconds, two BCD digits |
| min_bcd | input | 8 | Minutes, two BCD digits |
| hour_bcd | input | 8 | Hours, 24-hour, two BCD digits |
| date_bcd | input | 8 | Day of month, two BCD digits |
| month_bcd | input | 8 | Month, two BCD digits |
| year_bcd | input | 8 | Year within century, two BCD digits |
| dow | input | 3 | Day of week, 1 to 7 |
| alarm_hit | input | 1 | Alarm-match pulse |
| upd_req | input | 1 | Update request level |
| tev_sel | input | 2 | Time-boundary select |
| cev_sel | input | 2 | Calendar-boundary select |
| clr_wr | input | 1 | Clear-write strobe |
| clr_data | input | STAT_W | Clear mask, one bit per status bit |
| rd_strobe | input | 1 | Status read strobe |
| status | output | STAT_W | Status word |

## Verification
The assertions assume that `sec_tick`, `alarm_hit`, `clr_wr` and `rd_strobe` are single-cycle pulses sampled on the rising edge. They also assume that the time and calendar inputs change only between edges, and only together with a tick or while the unit is deliberately being fed bad data. The stimulus drives every input just after a falling edge. It holds the fields steady across each tick, and it places invalid values only inside the error-flag scenarios. Each boundary select is driven by stepping the fields through the exact transition it watches.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

    // status bit positions (bit order is visible to software)
    localparam int unsigned POS_GRANT = 0;
    localparam int unsigned POS_ALARM = 1;
    localparam int unsigned POS_SEC   = 2;
    localparam int unsigned POS_TEV   = 3;
    localparam int unsigned POS_CEV   = 4;
    localparam int unsigned POS_ERR   = 5;
    localparam int unsigned FLAG_N    = 6;
    localparam int unsigned CLR_N     = 5;  // bits reachable by the clear port

    localparam int unsigned DOW_W     = 3;
    localparam int unsigned DIGIT_N   = 12; // two digits for six byte fields

    typedef struct packed {
        logic [7:0]       sec;
        logic [7:0]       min;
        logic [7:0]       hour;
        logic [7:0]       date;
        logic [7:0]       month;
        logic [7:0]       year;
        logic [DOW_W-1:0] dow;
    } rtc_time_t;

    // packed so that the field order matches the status bit order
    typedef struct packed {
        logic err;
        logic cev;
        logic tev;
        logic sec;
        logic alarm;
        logic grant;
    } rtc_flags_t;

    typedef enum logic [1:0] {
        TEV_MINUTE   = 2'd0,
        TEV_HOUR     = 2'd1,
        TEV_MIDNIGHT = 2'd2,
        TEV_NOON     = 2'd3
    } tev_sel_e;

    typedef enum logic [1:0] {
        CEV_WEEK  = 2'd0,
        CEV_MONTH = 2'd1,
        CEV_YEAR  = 2'd2,
        CEV_NONE  = 2'd3
    } cev_sel_e;

endpackage

// File: rtl/rtc_time_check.sv
module rtc_time_check
    import rtc_evt_pkg::*;
(
    input  rtc_time_t t,
    output logic      bad
);
    logic [3:0]         digit [DIGIT_N];
    logic [DIGIT_N-1:0] digit_bad;
    logic               range_bad;

    always_comb begin
        digit[0]  = t.sec[3:0];
        digit[1]  = t.sec[7:4];
        digit[2]  = t.min[3:0];
        digit[3]  = t.min[7:4];
        digit[4]  = t.hour[3:0];
        digit[5]  = t.hour[7:4];
        digit[6]  = t.date[3:0];
        digit[7]  = t.date[7:4];
        digit[8]  = t.month[3:0];
        digit[9]  = t.month[7:4];
        digit[10] = t.year[3:0];
        digit[11] = t.year[7:4];
    end

    for (genvar g = 0; g < DIGIT_N; g++) begin : g_digit
        assign digit_bad[g] = (digit[g] > 4'd9);
    end

    // raw byte comparisons are valid once every nibble is a decimal digit
    always_comb begin
        range_bad = 1'b0;
        if (t.sec   > 8'h59)                     range_bad = 1'b1;
        if (t.min   > 8'h59)                     range_bad = 1'b1;
        if (t.hour  > 8'h23)                     range_bad = 1'b1;
        if (t.month == 8'h00 || t.month > 8'h12) range_bad = 1'b1;
        if (t.date  == 8'h00 || t.date  > 8'h31) range_bad = 1'b1;
        if (t.dow   == '0)                       range_bad = 1'b1;
    end

    assign bad = (|digit_bad) | range_bad;

endmodule

// File: rtl/rtc_boundary_detect.sv
module rtc_boundary_detect
    import rtc_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  rtc_time_t cur,
    input  tev_sel_e  tev_sel,
    input  cev_sel_e  cev_sel,
    output logic      tev_hit,
    output logic      cev_hit
);
    typedef struct packed {
        rtc_time_t prev;
        logic      seen;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       tev_d, cev_d;

    always_comb begin
        st_d  = st_q;
        tev_d = 1'b0;
        cev_d = 1'b0;
        if (tick) begin
            st_d.prev = cur;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                case (tev_sel)
                    TEV_MINUTE:   tev_d = (cur.min != st_q.prev.min);
                    TEV_HOUR:     tev_d = (cur.hour != st_q.prev.hour);
                    TEV_MIDNIGHT: tev_d = (cur.hour == 8'h00) &&
                                          (st_q.prev.hour != 8'h00);
                    TEV_NOON:     tev_d = (cur.hour == 8'h12) &&
                                          (st_q.prev.hour != 8'h12) &&
                                          (cur.min == 8'h00) &&
                                          (cur.sec == 8'h00);
                    default:      tev_d = 1'b0;
                endcase
                case (cev_sel)
                    CEV_WEEK:  cev_d = (cur.dow == DOW_W'(1)) &&
                                       (st_q.prev.dow != DOW_W'(1));
                    CEV_MONTH: cev_d = (cur.month != st_q.prev.month);
                    CEV_YEAR:  cev_d = (cur.year != st_q.prev.year);
                    default:   cev_d = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tev_hit = tev_d;
    assign cev_hit = cev_d;

endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status
    import rtc_evt_pkg::*;
#(
    parameter int unsigned STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [7:0]        sec_bcd,
    input  logic [7:0]        min_bcd,
    input  logic [7:0]        hour_bcd,
    input  logic [7:0]        date_bcd,
    input  logic [7:0]        month_bcd,
    input  logic [7:0]        year_bcd,
    input  logic [2:0]        dow,
    input  logic              alarm_hit,
    input  logic              upd_req,
    input  logic [1:0]        tev_sel,
    input  logic [1:0]        cev_sel,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_data,
    input  logic              rd_strobe,
    output logic [STAT_W-1:0] status
);
    localparam int unsigned PAD_W = STAT_W - FLAG_N;

    rtc_time_t  cur;
    logic       fields_bad;
    logic       tev_hit, cev_hit;
    logic [CLR_N-1:0] clr_bits;
    rtc_flags_t fl_d, fl_q;

    logic unused_clr;
    assign unused_clr = ^clr_data[STAT_W-1:CLR_N];

    always_comb begin
        cur.sec   = sec_bcd;
        cur.min   = min_bcd;
        cur.hour  = hour_bcd;
        cur.date  = date_bcd;
        cur.month = month_bcd;
        cur.year  = year_bcd;
        cur.dow   = dow;
    end

    rtc_time_check u_check (
        .t   (cur),
        .bad (fields_bad)
    );

    rtc_boundary_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .cur     (cur),
        .tev_sel (tev_sel_e'(tev_sel)),
        .cev_sel (cev_sel_e'(cev_sel)),
        .tev_hit (tev_hit),
        .cev_hit (cev_hit)
    );

    assign clr_bits = clr_wr ? clr_data[CLR_N-1:0] : '0;

    always_comb begin
        fl_d = fl_q;
        // clear first, so that a coincident set takes priority
        if (clr_bits[POS_GRANT]) fl_d.grant = 1'b0;
        if (clr_bits[POS_ALARM]) fl_d.alarm = 1'b0;
        if (clr_bits[POS_SEC])   fl_d.sec   = 1'b0;
        if (clr_bits[POS_TEV])   fl_d.tev   = 1'b0;
        if (clr_bits[POS_CEV])   fl_d.cev   = 1'b0;

        if (sec_tick)  fl_d.sec   = 1'b1;
        if (tev_hit)   fl_d.tev   = 1'b1;
        if (cev_hit)   fl_d.cev   = 1'b1;
        if (alarm_hit) fl_d.alarm = 1'b1;

        if (upd_req && sec_tick) fl_d.grant = 1'b1;
        if (!upd_req)            fl_d.grant = 1'b0;

        fl_d.err = fields_bad | (fl_q.err & ~rd_strobe);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign status = {{PAD_W{1'b0}}, fl_q};

endmodule

// File: rtl/rtc_evt_status_chk.sv
module rtc_evt_status_chk #(
    parameter int unsigned STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              alarm_hit,
    input logic              upd_req,
    input logic              clr_wr,
    input logic [STAT_W-1:0] clr_data,
    input logic              rd_strobe,
    input logic [STAT_W-1:0] status
);
    assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_W-1:6] == '0);

    assert_sec_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> status[2]);

    assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !(clr_wr && clr_data[2])) |=> status[2]);

    assert_alarm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> status[1]);

    assert_grant_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_req |=> !status[0]);

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !rd_strobe) |=> status[5]);

    assert_sec_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[2] && !sec_tick) |=> !status[2]);

    assert_alarm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[1] && !alarm_hit) |=> !status[1]);

endmodule

bind rtc_evt_status rtc_evt_status_chk #(.STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .alarm_hit (alarm_hit),
    .upd_req   (upd_req),
    .clr_wr    (clr_wr),
    .clr_data  (clr_data),
    .rd_strobe (rd_strobe),
    .status    (status)
);

// File: tb/tb_rtc_evt_status.sv
`timescale 1ns/1ps
module tb_rtc_evt_status;
    localparam int STAT_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sec_tick = 1'b0;
    logic [7:0]        sec_bcd = 8'h00, min_bcd = 8'h00, hour_bcd = 8'h10;
    logic [7:0]        date_bcd = 8'h15, month_bcd = 8'h06, year_bcd = 8'h24;
    logic [2:0]        dow = 3'd3;
    logic              alarm_hit = 1'b0;
    logic              upd_req = 1'b0;
    logic [1:0]        tev_sel = 2'd0;
    logic [1:0]        cev_sel = 2'd0;
    logic              clr_wr = 1'b0;
    logic [STAT_W-1:0] clr_data = '0;
    logic              rd_strobe = 1'b0;
    logic [STAT_W-1:0] status;

    always #2.5 clk = ~clk;

    rtc_evt_status #(.STAT_W(STAT_W)) dut (.*);

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int m_flag[6];
    int p_s, p_m, p_h, p_mo, p_y, p_dw;
    bit p_seen;

    function automatic bit dig_ok(input int x);
        return (x % 16) <= 9 && (x / 16) <= 9;
    endfunction

    function automatic int dec(input int x);
        return (x / 16) * 10 + (x % 16);
    endfunction

    function automatic int to_bcd(input int n);
        return (n / 10) * 16 + (n % 10);
    endfunction

    function automatic bit fields_ok();
        if (!dig_ok(sec_bcd) || !dig_ok(min_bcd) || !dig_ok(hour_bcd) ||
            !dig_ok(date_bcd) || !dig_ok(month_bcd) || !dig_ok(year_bcd))
            return 0;
        if (dec(sec_bcd) > 59 || dec(min_bcd) > 59 || dec(hour_bcd) > 23)
            return 0;
        if (dec(month_bcd) < 1 || dec(month_bcd) > 12) return 0;
        if (dec(date_bcd) < 1 || dec(date_bcd) > 31) return 0;
        if (dow < 1 || dow > 7) return 0;
        return 1;
    endfunction

    task automatic model_reset();
        foreach (m_flag[i]) m_flag[i] = 0;
        p_seen = 0;
    endtask

    task automatic model_edge();
        int tv, cv;
        tv = 0; cv = 0;
        if (clr_wr) begin
            for (int i = 0; i < 5; i++) if (clr_data[i]) m_flag[i] = 0;
        end
        if (sec_tick) begin
            m_flag[2] = 1;
            if (p_seen) begin
                case (tev_sel)
                    0: tv = (min_bcd != p_m);
                    1: tv = (hour_bcd != p_h);
                    2: tv = (hour_bcd == 0 && p_h != 0);
                    default: tv = (hour_bcd == 'h12 && p_h != 'h12 &&
                                   min_bcd == 0 && sec_bcd == 0);
                endcase
                case (cev_sel)
                    0: cv = (dow == 1 && p_dw != 1);
                    1: cv = (month_bcd != p_mo);
                    2: cv = (year_bcd != p_y);
                    default: cv = 0;
                endcase
            end
            p_s = sec_bcd; p_m = min_bcd; p_h = hour_bcd;
            p_mo = month_bcd; p_y = year_bcd; p_dw = dow; p_seen = 1;
            if (upd_req) m_flag[0] = 1;
        end
        if (tv) m_flag[3] = 1;
        if (cv) m_flag[4] = 1;
        if (alarm_hit) m_flag[1] = 1;
        if (!upd_req) m_flag[0] = 0;
        m_flag[5] = (!fields_ok() || (m_flag[5] && !rd_strobe)) ? 1 : 0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R6 grant bit0",   status[0], m_flag[0]);
        chk("R5 alarm bit1",   status[1], m_flag[1]);
        chk("R2 seconds bit2", status[2], m_flag[2]);
        chk("R3 time bit3",    status[3], m_flag[3]);
        chk("R4 cal bit4",     status[4], m_flag[4]);
        chk("R7 error bit5",   status[5], m_flag[5]);
        chk("R1 upper bits",   (status[STAT_W-1:6] == '0) ? 1 : 0, 1);
    endtask

    task automatic step();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic tick();
        sec_tick = 1'b1; step(); sec_tick = 1'b0; step();
    endtask

    task automatic set_time(input int h, input int m, input int s);
        hour_bcd = 8'(to_bcd(h)); min_bcd = 8'(to_bcd(m)); sec_bcd = 8'(to_bcd(s));
    endtask

    task automatic clear(input int mask);
        clr_wr = 1'b1; clr_data = STAT_W'(mask); step();
        clr_wr = 1'b0; clr_data = '0; step();
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) step();
        chk("R1 reset word", (status == '0) ? 1 : 0, 1);
        @(negedge clk); rst_n = 1'b1;
        step();

        // first tick: seconds only, no boundary flags
        set_time(10, 0, 0); tick();
        chk("R2 sec after tick", status[2], 1);
        chk("R3 no time flag on first tick", status[3], 0);
        clear('h04);
        chk("R8 seconds cleared", status[2], 0);

        // minute select
        tev_sel = 2'd0; set_time(10, 0, 1); tick();
        chk("R3 no minute change", status[3], 0);
        set_time(10, 1, 0); tick();
        chk("R3 minute change", status[3], 1);
        clear('h1F);

        // hour select
        tev_sel = 2'd1; set_time(10, 1, 1); tick();
        set_time(11, 0, 0); tick();
        chk("R3 hour change", status[3], 1);
        clear('h08);

        // noon select
        tev_sel = 2'd3; set_time(11, 59, 59); tick();
        chk("R3 not noon yet", status[3], 0);
        set_time(12, 0, 0); tick();
        chk("R3 noon", status[3], 1);
        clear('h08);
        set_time(12, 0, 1); tick();
        chk("R3 noon once", status[3], 0);

        // midnight select
        tev_sel = 2'd2; set_time(23, 59, 59); tick();
        set_time(0, 0, 0); tick();
        chk("R3 midnight", status[3], 1);
        clear('h1F);

        // week, month, year, none
        cev_sel = 2'd0; dow = 3'd7; tick();
        dow = 3'd1; tick();
        chk("R4 week wrap", status[4], 1);
        clear('h10);
        cev_sel = 2'd1; month_bcd = 8'h07; tick();
        chk("R4 month change", status[4], 1);
        clear('h10);
        cev_sel = 2'd2; year_bcd = 8'h25; tick();
        chk("R4 year change", status[4], 1);
        clear('h10);
        cev_sel = 2'd3; year_bcd = 8'h26; month_bcd = 8'h01; tick();
        chk("R4 select none", status[4], 0);

        // alarm, and set beats clear
        alarm_hit = 1'b1; step(); alarm_hit = 1'b0; step();
        chk("R5 alarm", status[1], 1);
        alarm_hit = 1'b1; clr_wr = 1'b1; clr_data = 'h02; step();
        alarm_hit = 1'b0; clr_wr = 1'b0; clr_data = '0; step();
        chk("R8 set wins over clear", status[1], 1);
        clear('h02);
        chk("R8 alarm cleared", status[1], 0);

        // update grant
        upd_req = 1'b1; step(); step();
        chk("R6 no grant before tick", status[0], 0);
        tick();
        chk("R6 grant after tick", status[0], 1);
        clear('h01);
        chk("R8 grant cleared", status[0], 0);
        tick();
        chk("R6 grant again", status[0], 1);
        upd_req = 1'b0; step();
        chk("R6 grant dropped", status[0], 0);

        // error flag
        sec_bcd = 8'h5A; step();
        chk("R7 non-BCD seconds", status[5], 1);
        rd_strobe = 1'b1; step(); rd_strobe = 1'b0; step();
        chk("R7 read while invalid", status[5], 1);
        sec_bcd = 8'h10; step(); step();
        chk("R7 sticky after fix", status[5], 1);
        clear('h3F);
        chk("R8 clear ignores bit5", status[5], 1);
        rd_strobe = 1'b1; step(); rd_strobe = 1'b0; step();
        chk("R7 read clears", status[5], 0);
        month_bcd = 8'h13; step();
        chk("R7 month range", status[5], 1);
        month_bcd = 8'h12; hour_bcd = 8'h24; rd_strobe = 1'b1; step();
        rd_strobe = 1'b0; step();
        chk("R7 hour range", status[5], 1);
        hour_bcd = 8'h23; date_bcd = 8'h00; step();
        date_bcd = 8'h31; dow = 3'd0; step();
        dow = 3'd5; rd_strobe = 1'b1; step(); rd_strobe = 1'b0; step();
        chk("R7 all valid then read", status[5], 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule